// File: doc/BRIEF.md
# Floating-Point Register Mode Switch Controller

This block keeps the floating-point register mode bit (FR) of a 32-bit core and two configuration words that decide whether user code may change it. It sits beside the instruction decode stage. Coprocessor-1 control moves reach it as a register number, the index of the general register that supplies the data, and a read or write strobe. Coprocessor-0 configuration moves reach it as a select value, write data and a read or write strobe.

User code reads FR through FPU control number 1. It clears FR by writing control number 1 and sets FR by writing control number 4. A fixed implementation word, given as a parameter, says whether this path is built at all. A bit in the second configuration word enables it at run time. An access that is built but disabled raises a reserved-instruction pulse. Configuration writes merge the new data through a writable-bit mask that is fixed per word. Every configuration write and every successful FR change produces a one-cycle refetch pulse, so the pipeline discards instructions fetched under the old mode.

Top module: `fpu_mode_ctrl`

## Requirements
- R1: After reset: `fr_o` is 0, `ri_exc_o` and `refetch_o` are 0, configuration select 4 reads 32'h8000_0000 and configuration select 5 reads 32'h0000_0004.
- R2: An FPU control read of number 0 returns the implementation word `FIR_VALUE` on `fcr_rdata_o` in the same cycle. The default is 32'h1070_0000, in which bit 28 is the capability bit.
- R3: When the capability bit is set and enable bit 2 of configuration word 5 is set, an FPU control read of number 1 returns FR in bit 0, with every other bit 0, in the same cycle.
- R4: When the capability bit is set and the enable bit is clear, an FPU control read of number 1 returns 0 and raises `ri_exc_o` for exactly the cycle after the strobe.
- R5: When the capability bit is clear, an FPU control read of number 1 returns 0 without an exception. FPU control writes to numbers 1 and 4 then do not change FR and produce no pulse.
- R6: When the capability bit and the enable bit are both set, an FPU control write with source index 0 clears FR if the number is 1 and sets FR if the number is 4. The new FR appears, and `refetch_o` pulses, in the cycle after the strobe. This happens even if FR already had that value.
- R7: An FPU control write to number 1 or 4 with a nonzero source index does nothing: FR keeps its value, and no exception and no refetch occur, whatever the enable bit is.
- R8: An FPU control write to number 1 or 4 with source index 0, made while the capability bit is set and the enable bit is clear, raises `ri_exc_o` for one cycle. FR keeps its value and no refetch occurs.
- R9: A configuration write to select 4 or 5 sets the word to (old AND NOT mask) OR (data AND mask). The mask for select 4 is 0. The mask for select 5 is 32'h6800_0004, which covers bits 30, 29, 27 and 2.
- R10: A configuration write to select 4 or 5 pulses `refetch_o` in the following cycle. A write to any other select changes nothing, produces no pulse, and that select reads back as 0.
- R11: FPU control numbers other than 0, 1 and 4 read back as 0, and writes to them have no effect on FR or on either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fcr_rd_i | input | 1 | FPU control read strobe |
| fcr_wr_i | input | 1 | FPU control write strobe |
| fcr_num_i | input | 5 | FPU control register number |
| fcr_src_i | input | 5 | Index of the source general register of a write |
| fcr_rdata_o | output | 32 | FPU control read data, valid in the cycle of the strobe |
| cfg_rd_i | input | 1 | Configuration read strobe |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration word select (4 or 5 are implemented) |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data, valid in the cycle of the strobe |
| fr_o | output | 1 | Current FR mode bit |
| ri_exc_o | output | 1 | Reserved-instruction pulse |
| refetch_o | output | 1 | Stop-and-refetch pulse |

## Verification
The properties assume that the decode stage never issues an FPU control read and write in the same cycle. The bench keeps to this by raising one strobe per access and putting an idle cycle between accesses, so that each pulse can be tied to a single access. The checks that relate FR changes and exceptions to refetch pulses also assume that reset is the only other source of FR changes. Capability-clear behaviour is exercised on a second instance that is built with that bit clear.

// File: rtl/fpu_mode_pkg.sv
package fpu_mode_pkg;
  localparam logic [4:0] FIR_NUM      = 5'd0;
  localparam logic [4:0] FR_ALIAS_CLR = 5'd1;  // also the FR read alias
  localparam logic [4:0] FR_ALIAS_SET = 5'd4;
  localparam logic [2:0] CFG4_SEL     = 3'd4;
  localparam int unsigned NUM_CFG     = 2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_EXC  = 2'd3
  } alias_act_e;
endpackage

// File: rtl/fr_alias_dec.sv
module fr_alias_dec
  import fpu_mode_pkg::*;
#(
  parameter int unsigned          W         = 32,
  parameter int unsigned          SRC_W     = 5,
  parameter logic [W-1:0]         FIR_VALUE = '0
) (
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [4:0]       num_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic             cap_i,
  input  logic             en_i,
  input  logic             fr_i,
  output logic [W-1:0]     rdata_o,
  output alias_act_e       act_o
);
  always_comb begin
    rdata_o = '0;
    act_o   = ACT_NONE;
    if (rd_i) begin
      if (num_i == FIR_NUM) begin
        rdata_o = FIR_VALUE;
      end else if (num_i == FR_ALIAS_CLR && cap_i) begin
        if (en_i) rdata_o = {{(W-1){1'b0}}, fr_i};
        else      act_o   = ACT_EXC;
      end
    end else if (wr_i && cap_i && src_i == '0) begin
      if (num_i == FR_ALIAS_CLR)      act_o = en_i ? ACT_CLR : ACT_EXC;
      else if (num_i == FR_ALIAS_SET) act_o = en_i ? ACT_SET : ACT_EXC;
    end
  end
endmodule

// File: rtl/masked_cfg_reg.sv
module masked_cfg_reg #(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] RST  = '0,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= (q_o & ~MASK) | (wdata_i & MASK);
  end
endmodule

// File: rtl/fpu_mode_ctrl.sv
module fpu_mode_ctrl
  import fpu_mode_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     SRC_W      = 5,
  parameter logic [XLEN-1:0] FIR_VALUE  = 32'h1070_0000,
  parameter int unsigned     UFRP_BIT   = 28,
  parameter int unsigned     UFR_EN_BIT = 2,
  parameter logic [XLEN-1:0] CFG4_RST   = 32'h8000_0000,
  parameter logic [XLEN-1:0] CFG4_MASK  = 32'h0000_0000,
  parameter logic [XLEN-1:0] CFG5_RST   = 32'h0000_0004,
  parameter logic [XLEN-1:0] CFG5_MASK  = 32'h6800_0004
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fcr_rd_i,
  input  logic             fcr_wr_i,
  input  logic [4:0]       fcr_num_i,
  input  logic [SRC_W-1:0] fcr_src_i,
  output logic [XLEN-1:0]  fcr_rdata_o,
  input  logic             cfg_rd_i,
  input  logic             cfg_wr_i,
  input  logic [2:0]       cfg_sel_i,
  input  logic [XLEN-1:0]  cfg_wdata_i,
  output logic [XLEN-1:0]  cfg_rdata_o,
  output logic             fr_o,
  output logic             ri_exc_o,
  output logic             refetch_o
);
  localparam logic [NUM_CFG-1:0][XLEN-1:0] CFG_RST  = {CFG5_RST, CFG4_RST};
  localparam logic [NUM_CFG-1:0][XLEN-1:0] CFG_MASK = {CFG5_MASK, CFG4_MASK};
  localparam logic CAP = FIR_VALUE[UFRP_BIT];

  logic [NUM_CFG-1:0][XLEN-1:0] cfg_q;
  logic [NUM_CFG-1:0]           cfg_we;
  alias_act_e                   act;
  logic                         fr_q, exc_q, refetch_q;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    assign cfg_we[i] = cfg_wr_i && (cfg_sel_i == CFG4_SEL + 3'(i));
    masked_cfg_reg #(
      .W    (XLEN),
      .RST  (CFG_RST[i]),
      .MASK (CFG_MASK[i])
    ) u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we[i]),
      .wdata_i (cfg_wdata_i),
      .q_o     (cfg_q[i])
    );
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (cfg_rd_i && cfg_sel_i == CFG4_SEL + 3'(i)) cfg_rdata_o = cfg_q[i];
  end

  fr_alias_dec #(
    .W         (XLEN),
    .SRC_W     (SRC_W),
    .FIR_VALUE (FIR_VALUE)
  ) u_dec (
    .rd_i    (fcr_rd_i),
    .wr_i    (fcr_wr_i),
    .num_i   (fcr_num_i),
    .src_i   (fcr_src_i),
    .cap_i   (CAP),
    .en_i    (cfg_q[1][UFR_EN_BIT]),
    .fr_i    (fr_q),
    .rdata_o (fcr_rdata_o),
    .act_o   (act)
  );

  // Exception wins: ACT_EXC never touches FR or refetch.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_q      <= 1'b0;
      exc_q     <= 1'b0;
      refetch_q <= 1'b0;
    end else begin
      exc_q     <= (act == ACT_EXC);
      refetch_q <= (act == ACT_CLR) || (act == ACT_SET) || (|cfg_we);
      if (act == ACT_CLR)      fr_q <= 1'b0;
      else if (act == ACT_SET) fr_q <= 1'b1;
    end
  end

  assign fr_o      = fr_q;
  assign ri_exc_o  = exc_q;
  assign refetch_o = refetch_q;
endmodule

// File: rtl/fpu_mode_ctrl_chk.sv
module fpu_mode_ctrl_chk #(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] FIR_VALUE  = '0,
  parameter int unsigned     UFRP_BIT   = 28,
  parameter int unsigned     UFR_EN_BIT = 2,
  parameter logic [XLEN-1:0] CFG4_MASK  = '0,
  parameter logic [XLEN-1:0] CFG5_MASK  = '0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fcr_rd_i,
  input logic            fcr_wr_i,
  input logic [4:0]      fcr_num_i,
  input logic [XLEN-1:0] fcr_rdata_o,
  input logic            cfg_wr_i,
  input logic [XLEN-1:0] cfg4_q,
  input logic [XLEN-1:0] cfg5_q,
  input logic            fr_o,
  input logic            ri_exc_o,
  input logic            refetch_o
);
  localparam logic CAP = FIR_VALUE[UFRP_BIT];

  a_in_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fcr_rd_i && fcr_wr_i));

  a_r3_read_fr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_rd_i && fcr_num_i == 5'd1 && CAP && cfg5_q[UFR_EN_BIT])
      |-> fcr_rdata_o == {{(XLEN-1){1'b0}}, fr_o});

  a_r4_exc_from_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_exc_o |-> $past(fcr_rd_i || fcr_wr_i));

  a_r5_no_exc_without_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !CAP |-> !ri_exc_o);

  a_r6_fr_change_refetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr_o != $past(fr_o)) |-> refetch_o);

  a_r8_exc_keeps_fr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_exc_o |-> (fr_o == $past(fr_o)) && !refetch_o);

  a_r9_cfg4_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg4_q ^ $past(cfg4_q)) & ~CFG4_MASK) == '0);

  a_r9_cfg5_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg5_q ^ $past(cfg5_q)) & ~CFG5_MASK) == '0);

  a_r10_refetch_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refetch_o |-> $past(fcr_wr_i || cfg_wr_i));
endmodule

bind fpu_mode_ctrl fpu_mode_ctrl_chk #(
  .XLEN       (XLEN),
  .FIR_VALUE  (FIR_VALUE),
  .UFRP_BIT   (UFRP_BIT),
  .UFR_EN_BIT (UFR_EN_BIT),
  .CFG4_MASK  (CFG4_MASK),
  .CFG5_MASK  (CFG5_MASK)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fcr_rd_i    (fcr_rd_i),
  .fcr_wr_i    (fcr_wr_i),
  .fcr_num_i   (fcr_num_i),
  .fcr_rdata_o (fcr_rdata_o),
  .cfg_wr_i    (cfg_wr_i),
  .cfg4_q      (cfg_q[0]),
  .cfg5_q      (cfg_q[1]),
  .fr_o        (fr_o),
  .ri_exc_o    (ri_exc_o),
  .refetch_o   (refetch_o)
);

// File: tb/fpu_mode_ctrl_tb.sv
module fpu_mode_ctrl_tb;
  localparam logic [31:0] FIR_CAP   = 32'h1070_0000;
  localparam logic [31:0] FIR_NOCAP = 32'h0070_0000;

  typedef enum logic [1:0] {OP_FRD = 2'd0, OP_FWR = 2'd1, OP_CRD = 2'd2, OP_CWR = 2'd3} op_e;
  typedef struct packed {
    op_e         op;
    logic [4:0]  num;   // FPU number, or config select in low 3 bits
    logic [4:0]  src;
    logic [31:0] data;
    logic [31:0] exp_rd;
    logic        exp_fr;
    logic        exp_exc;
    logic        exp_ref;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{OP_FRD, 5'd0,  5'd0, 32'h0, FIR_CAP,      1'b0, 1'b0, 1'b0, 8'd2},  // R2
    '{OP_FRD, 5'd1,  5'd0, 32'h0, 32'h0,        1'b0, 1'b0, 1'b0, 8'd3},  // R3
    '{OP_FWR, 5'd4,  5'd0, 32'h0, 32'h0,        1'b1, 1'b0, 1'b1, 8'd6},  // R6 set
    '{OP_FRD, 5'd1,  5'd0, 32'h0, 32'h1,        1'b1, 1'b0, 1'b0, 8'd3},  // R3
    '{OP_FWR, 5'd4,  5'd3, 32'h0, 32'h0,        1'b1, 1'b0, 1'b0, 8'd7},  // R7
    '{OP_FWR, 5'd1,  5'd7, 32'h0, 32'h0,        1'b1, 1'b0, 1'b0, 8'd7},  // R7
    '{OP_FWR, 5'd1,  5'd0, 32'h0, 32'h0,        1'b0, 1'b0, 1'b1, 8'd6},  // R6 clear
    '{OP_FWR, 5'd25, 5'd0, 32'h0, 32'h0,        1'b0, 1'b0, 1'b0, 8'd11}, // R11
    '{OP_FRD, 5'd25, 5'd0, 32'h0, 32'h0,        1'b0, 1'b0, 1'b0, 8'd11}, // R11
    '{OP_CWR, 5'd5,  5'd0, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b1, 8'd10}, // R10
    '{OP_CRD, 5'd5,  5'd0, 32'h0, 32'h6800_0004, 1'b0, 1'b0, 1'b0, 8'd9}, // R9
    '{OP_CWR, 5'd5,  5'd0, 32'h0, 32'h0,        1'b0, 1'b0, 1'b1, 8'd10}, // R10
    '{OP_CRD, 5'd5,  5'd0, 32'h0, 32'h0,        1'b0, 1'b0, 1'b0, 8'd9},  // R9
    '{OP_FRD, 5'd1,  5'd0, 32'h0, 32'h0,        1'b0, 1'b1, 1'b0, 8'd4},  // R4
    '{OP_FWR, 5'd4,  5'd0, 32'h0, 32'h0,        1'b0, 1'b1, 1'b0, 8'd8},  // R8
    '{OP_FWR, 5'd4,  5'd2, 32'h0, 32'h0,        1'b0, 1'b0, 1'b0, 8'd7},  // R7 disabled
    '{OP_CWR, 5'd4,  5'd0, 32'h1234_5678, 32'h0, 1'b0, 1'b0, 1'b1, 8'd10}, // R10
    '{OP_CRD, 5'd4,  5'd0, 32'h0, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 8'd9}, // R9
    '{OP_CWR, 5'd3,  5'd0, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b0, 8'd10}, // R10 other sel
    '{OP_CRD, 5'd3,  5'd0, 32'h0, 32'h0,        1'b0, 1'b0, 1'b0, 8'd10}, // R10
    '{OP_CWR, 5'd5,  5'd0, 32'h9000_0004, 32'h0, 1'b0, 1'b0, 1'b1, 8'd9}, // R9
    '{OP_CRD, 5'd5,  5'd0, 32'h0, 32'h0000_0004, 1'b0, 1'b0, 1'b0, 8'd9}, // R9
    '{OP_FWR, 5'd4,  5'd0, 32'h0, 32'h0,        1'b1, 1'b0, 1'b1, 8'd6}   // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fcr_rd = 1'b0, fcr_wr = 1'b0, cfg_rd = 1'b0, cfg_wr = 1'b0;
  logic        nc_rd = 1'b0, nc_wr = 1'b0;
  logic [4:0]  fcr_num = '0, fcr_src = '0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] fcr_rdata, cfg_rdata, nc_fcr_rdata, nc_cfg_rdata;
  logic        fr, exc, refetch, nc_fr, nc_exc, nc_refetch;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  fpu_mode_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fcr_rd_i(fcr_rd), .fcr_wr_i(fcr_wr), .fcr_num_i(fcr_num), .fcr_src_i(fcr_src),
    .fcr_rdata_o(fcr_rdata),
    .cfg_rd_i(cfg_rd), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .fr_o(fr), .ri_exc_o(exc), .refetch_o(refetch)
  );

  fpu_mode_ctrl #(.FIR_VALUE(FIR_NOCAP)) u_dut_nocap (
    .clk_i(clk), .rst_ni(rst_n),
    .fcr_rd_i(nc_rd), .fcr_wr_i(nc_wr), .fcr_num_i(fcr_num), .fcr_src_i(fcr_src),
    .fcr_rdata_o(nc_fcr_rdata),
    .cfg_rd_i(1'b0), .cfg_wr_i(1'b0), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(nc_cfg_rdata),
    .fr_o(nc_fr), .ri_exc_o(nc_exc), .refetch_o(nc_refetch)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_read(input logic [2:0] sel, output logic [31:0] val);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_sel = sel;
    #1 val = cfg_rdata;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    fcr_num = v.num; fcr_src = v.src; cfg_sel = v.num[2:0]; cfg_wdata = v.data;
    fcr_rd = (v.op == OP_FRD); fcr_wr = (v.op == OP_FWR);
    cfg_rd = (v.op == OP_CRD); cfg_wr = (v.op == OP_CWR);
    #1;
    if (v.op == OP_CRD) check(tag, "cfg_rdata", cfg_rdata, v.exp_rd);
    else                check(tag, "fcr_rdata", fcr_rdata, v.exp_rd);
    @(posedge clk);
    @(negedge clk);
    fcr_rd = 1'b0; fcr_wr = 1'b0; cfg_rd = 1'b0; cfg_wr = 1'b0;
    check(tag, "fr", 32'(fr), 32'(v.exp_fr));
    check(tag, "ri_exc", 32'(exc), 32'(v.exp_exc));
    check(tag, "refetch", 32'(refetch), 32'(v.exp_ref));
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", "fr", 32'(fr), 32'h0);
    check("R1", "ri_exc", 32'(exc), 32'h0);
    check("R1", "refetch", 32'(refetch), 32'h0);
    cfg_read(3'd4, rv); check("R1", "cfg4", rv, 32'h8000_0000);
    cfg_read(3'd5, rv); check("R1", "cfg5", rv, 32'h0000_0004);

    // R5 capability clear
    @(negedge clk);
    nc_rd = 1'b1; fcr_num = 5'd1; fcr_src = '0;
    #1 check("R5", "nocap rd1", nc_fcr_rdata, 32'h0);
    @(negedge clk);
    nc_rd = 1'b0;
    check("R5", "nocap exc", 32'(nc_exc), 32'h0);
    nc_wr = 1'b1; fcr_num = 5'd4;
    @(negedge clk);
    nc_wr = 1'b0;
    check("R5", "nocap fr", 32'(nc_fr), 32'h0);
    check("R5", "nocap exc wr", 32'(nc_exc), 32'h0);
    check("R5", "nocap refetch", 32'(nc_refetch), 32'h0);
    nc_rd = 1'b1; fcr_num = 5'd0;
    #1 check("R2", "nocap fir", nc_fcr_rdata, FIR_NOCAP);
    @(negedge clk);
    nc_rd = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R1 reset in mid-run: FR was set, cfg5 rewritten
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", "fr after reset", 32'(fr), 32'h0);
    cfg_read(3'd5, rv); check("R1", "cfg5 after reset", rv, 32'h0000_0004);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule